// File: doc/BRIEF.md
# Hardware store request controller

This block sequences a nonvolatile backup of an SRAM that is started from a single active-low request pin. The request pin is shared: an external agent pulls it low to ask for a backup, and the block pulls the same line low, through an open-drain enable, to signal that it is busy. A low level is accepted as a request only after it has been seen for a minimum number of clock cycles. Shorter dips are treated as glitches and dropped.

Once a request is accepted, the block decides whether a copy is needed. It does this by checking a dirty flag. The flag is set by any SRAM write and cleared when a store or a recall finishes. If the memory is dirty, the block first lets any SRAM cycle already in flight finish, but it waits no longer than a bounded number of cycles. It then issues a one-cycle start to the storage array and keeps the busy pull active until the array reports completion. Whether or not a copy ran, memory access stays inhibited until the request pin goes high again. If a copy did run, access stays inhibited for a further recovery interval after that. All durations are clock counts set by parameters.

Top module: `hsb_store_ctrl`

## Requirements
- R1: After reset, `inhibit`, `hsb_pull` and `store_start` are 0 and the memory is clean, so a first request with no prior write starts no store.
- R2: A low level on `hsb_in` sampled on fewer than MIN_LOW_CYC consecutive rising edges is ignored: `inhibit` and `hsb_pull` stay 0.
- R3: When `hsb_in` is sampled low on MIN_LOW_CYC consecutive edges, `inhibit` rises on the next edge. If the memory is dirty, `hsb_pull` rises on that same edge.
- R4: A request accepted while the memory is clean gives no `store_start` and no `hsb_pull`. `inhibit` is held while `hsb_in` stays low and drops on the edge that samples `hsb_in` high, with no recovery interval.
- R5: While dirty and waiting, `store_start` is issued on the edge after `cyc_busy` is first sampled low following acceptance.
- R6: If `cyc_busy` stays high, `store_start` is issued DELAY_CYC edges after acceptance at the latest.
- R7: `store_start` is a single-cycle pulse. `hsb_pull` stays high from acceptance until `store_done` is sampled, and is low from the next edge on.
- R8: After a store, `inhibit` stays high while `hsb_in` is low. After the edge that samples `hsb_in` high, it stays high for RECOVER_CYC further edges.
- R9: `sram_we` sets the dirty state and `recall_done` clears it. When both occur in the same cycle, the write wins and the memory stays dirty.
- R10: If `hsb_in` returns high while a store is running, the store still completes, and the recovery interval begins on the edge after `store_done` is accepted.
- R11: `hsb_pull` is never active without `inhibit`.

Parameters: MIN_LOW_CYC=3, DELAY_CYC=8, RECOVER_CYC=6 (all at least 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsb_in | input | 1 | Level of the shared request/busy pin (low = request) |
| sram_we | input | 1 | SRAM write strobe, one pulse per write |
| recall_done | input | 1 | Pulse when a nonvolatile-to-SRAM recall finishes |
| cyc_busy | input | 1 | An SRAM access cycle is in progress |
| store_done | input | 1 | Storage array reports the copy finished |
| store_start | output | 1 | One-cycle command to begin the copy |
| hsb_pull | output | 1 | Open-drain enable: 1 pulls the shared pin low (busy) |
| inhibit | output | 1 | Blocks SRAM chip enable and output drivers |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- Glitches one cycle shorter than the acceptance threshold. A filter that is off by one would lock out the memory on noise.
- Requests with a clean memory, including one just after a recall. A design that ignores the dirty state would run a needless copy and enforce a recovery that should not be there.
- Cycle-in-progress holds both below and beyond the delay cap. These expose a launch that comes a cycle early or late, or a wait that never ends.
- An early release of the request pin during a copy, and a write that collides with a recall. A wrong design would cut the store short, skip recovery, or lose a write that happened during the clear.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAIT   = 3'd1,
    ST_LAUNCH = 3'd2,
    ST_RUN    = 3'd3,
    ST_HOLD   = 3'd4,
    ST_RECOV  = 3'd5
  } hsb_state_t;
endpackage

// File: rtl/hsb_glitch_filter.sv
module hsb_glitch_filter #(
  parameter int MIN_LOW_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic req
);
  localparam int CW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW_CYC);

  logic [CW-1:0] low_cnt_q, low_cnt_d;

  always_comb begin
    if (pin_n)
      low_cnt_d = '0;
    else if (low_cnt_q == LIMIT)
      low_cnt_d = low_cnt_q;
    else
      low_cnt_d = low_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt_q <= '0;
    else        low_cnt_q <= low_cnt_d;
  end

  assign req = (low_cnt_q == LIMIT);
endmodule

// File: rtl/hsb_dirty_tracker.sv
module hsb_dirty_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic set_wr,
  input  logic clr,
  output logic dirty
);
  logic dirty_q, dirty_d;

  always_comb begin
    dirty_d = dirty_q;
    if (clr)    dirty_d = 1'b0;
    if (set_wr) dirty_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dirty_q <= 1'b0;
    else        dirty_q <= dirty_d;
  end

  assign dirty = dirty_q;
endmodule

// File: rtl/hsb_seq.sv
module hsb_seq
  import hsb_pkg::*;
#(
  parameter int DELAY_CYC   = 8,
  parameter int RECOVER_CYC = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       pin_n,
  input  logic       dirty,
  input  logic       cyc_busy,
  input  logic       store_done,
  output hsb_state_t state
);
  localparam int MAXC = (DELAY_CYC > RECOVER_CYC) ? DELAY_CYC : RECOVER_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(RECOVER_CYC - 1);

  hsb_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          stored_q, stored_d;
  logic          cnt_en;

  always_comb begin
    state_d  = state_q;
    stored_d = stored_q;
    cnt_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        stored_d = 1'b0;
        if (req) state_d = dirty ? ST_WAIT : ST_HOLD;
      end
      ST_WAIT: begin
        if (!cyc_busy || cnt_q == DLY_LAST) state_d = ST_LAUNCH;
        else                                cnt_en  = 1'b1;
      end
      ST_LAUNCH: begin
        stored_d = 1'b1;
        state_d  = ST_RUN;
      end
      ST_RUN: begin
        if (store_done) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (pin_n) state_d = stored_q ? ST_RECOV : ST_IDLE;
      end
      ST_RECOV: begin
        if (cnt_q == REC_LAST) state_d = ST_IDLE;
        else                   cnt_en  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (state_d != state_q) cnt_d = '0;
    else if (cnt_en)        cnt_d = cnt_q + 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      stored_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      stored_q <= stored_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/hsb_store_ctrl.sv
module hsb_store_ctrl
  import hsb_pkg::*;
#(
  parameter int MIN_LOW_CYC = 3,
  parameter int DELAY_CYC   = 8,
  parameter int RECOVER_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsb_in,
  input  logic sram_we,
  input  logic recall_done,
  input  logic cyc_busy,
  input  logic store_done,
  output logic store_start,
  output logic hsb_pull,
  output logic inhibit
);
  hsb_state_t state;
  logic       req;
  logic       dirty_q;
  logic       clr_dirty;

  hsb_glitch_filter #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (hsb_in),
    .req   (req)
  );

  assign clr_dirty = recall_done | ((state == ST_RUN) & store_done);

  hsb_dirty_tracker u_dirty (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_wr (sram_we),
    .clr    (clr_dirty),
    .dirty  (dirty_q)
  );

  hsb_seq #(.DELAY_CYC(DELAY_CYC), .RECOVER_CYC(RECOVER_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .pin_n      (hsb_in),
    .dirty      (dirty_q),
    .cyc_busy   (cyc_busy),
    .store_done (store_done),
    .state      (state)
  );

  assign store_start = (state == ST_LAUNCH);
  assign hsb_pull    = (state == ST_WAIT) | (state == ST_LAUNCH) | (state == ST_RUN);
  assign inhibit     = (state != ST_IDLE);
endmodule

// File: rtl/hsb_store_ctrl_chk.sv
module hsb_store_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic store_start,
  input logic hsb_pull,
  input logic inhibit,
  input logic dirty
);
  a_r7_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |=> !store_start);

  a_r11_pull_needs_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    hsb_pull |-> inhibit);

  a_r3_pull_only_when_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsb_pull) |-> $past(dirty));

  a_r7_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> hsb_pull);

  a_r8_standby_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsb_pull) |-> inhibit);
endmodule

bind hsb_store_ctrl hsb_store_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .store_start (store_start),
  .hsb_pull    (hsb_pull),
  .inhibit     (inhibit),
  .dirty       (dirty_q)
);

// File: tb/tb_hsb_store_ctrl.sv
`timescale 1ns/1ps
module tb_hsb_store_ctrl;
  localparam int G   = 3;
  localparam int DLY = 8;
  localparam int REC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsb_in = 1'b1;
  logic sram_we = 1'b0;
  logic recall_done = 1'b0;
  logic cyc_busy = 1'b0;
  logic store_done = 1'b0;
  logic store_start, hsb_pull, inhibit;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit exp_dirty = 1'b0;

  always #4 clk = ~clk;

  hsb_store_ctrl #(.MIN_LOW_CYC(G), .DELAY_CYC(DLY), .RECOVER_CYC(REC)) dut (
    .clk(clk), .rst_n(rst_n), .hsb_in(hsb_in), .sram_we(sram_we),
    .recall_done(recall_done), .cyc_busy(cyc_busy), .store_done(store_done),
    .store_start(store_start), .hsb_pull(hsb_pull), .inhibit(inhibit)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_launch(input int busy_len);
    return (busy_len + 1 < DLY) ? busy_len + 1 : DLY;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_write();
    @(negedge clk) sram_we = 1'b1;
    @(negedge clk) sram_we = 1'b0;
    exp_dirty = 1'b1;
  endtask

  task automatic do_recall();
    @(negedge clk) recall_done = 1'b1;
    @(negedge clk) recall_done = 1'b0;
    exp_dirty = 1'b0;
  endtask

  task automatic do_collide();
    @(negedge clk) begin sram_we = 1'b1; recall_done = 1'b1; end
    @(negedge clk) begin sram_we = 1'b0; recall_done = 1'b0; end
    exp_dirty = 1'b1; // R9: write wins
  endtask

  task automatic do_glitch(input int g);
    bit ok = 1'b1;
    @(negedge clk) hsb_in = 1'b0;
    repeat (g) @(negedge clk) ok &= !inhibit && !hsb_pull;
    hsb_in = 1'b1;
    repeat (G + 3) @(negedge clk) ok &= !inhibit && !hsb_pull;
    check(ok, "R2 glitch ignored", int'(inhibit), 0);
  endtask

  task automatic do_request(input int busy_len, input int lat, input bit early);
    bit ok = 1'b1;
    int seen = -1;
    int n;
    @(negedge clk) hsb_in = 1'b0;
    for (int i = 1; i <= G; i++) begin
      @(negedge clk) ok &= !inhibit;
    end
    check(ok, "R3 no inhibit before threshold", int'(inhibit), 0);
    @(negedge clk);
    check(inhibit == 1'b1, "R3 inhibit on acceptance", int'(inhibit), 1);
    check(hsb_pull == exp_dirty, exp_dirty ? "R3 busy pull when dirty" : "R4 no pull when clean",
          int'(hsb_pull), int'(exp_dirty));
    if (exp_dirty) begin
      cyc_busy = (busy_len > 0);
      for (int k = 1; k <= DLY + 2; k++) begin
        @(negedge clk);
        if (store_start) begin seen = k; break; end
        cyc_busy = (k < busy_len);
      end
      cyc_busy = 1'b0;
      check(seen == exp_launch(busy_len),
            (busy_len + 1 < DLY) ? "R5 launch after cycle ends" : "R6 launch at delay cap",
            seen, exp_launch(busy_len));
      if (early) hsb_in = 1'b1;
      @(negedge clk);
      check(!store_start && hsb_pull, "R7 start single pulse, pull held", int'(store_start), 0);
      ok = 1'b1;
      repeat (lat) @(negedge clk) ok &= hsb_pull;
      check(ok, "R7 pull held until done", int'(hsb_pull), 1);
      store_done = 1'b1;
      @(negedge clk) store_done = 1'b0;
      check(!hsb_pull, "R7 pull released after done", int'(hsb_pull), 0);
      check(inhibit, "R8 inhibit after store", int'(inhibit), 1);
      if (!early) begin
        ok = 1'b1;
        repeat (3) @(negedge clk) ok &= inhibit;
        check(ok, "R8 standby while request low", int'(inhibit), 1);
        hsb_in = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (inhibit && n < 50);
        check(n == REC + 1, "R8 recovery length", n, REC + 1);
      end else begin
        n = 1;
        do begin @(negedge clk); n++; end while (inhibit && n < 50);
        check(n == REC + 2, "R10 early release recovery", n, REC + 2);
      end
      exp_dirty = 1'b0;
    end else begin
      ok = 1'b1;
      repeat (4) @(negedge clk) ok &= inhibit && !hsb_pull && !store_start;
      check(ok, "R4 clean standby without store", int'(store_start), 0);
      hsb_in = 1'b1;
      @(negedge clk);
      check(!inhibit, "R4 no recovery when clean", int'(inhibit), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!inhibit && !hsb_pull && !store_start, "R1 reset outputs", int'(inhibit), 0);
    do_request(0, 1, 1'b0);                        // R1: clean after reset
    do_glitch(G - 1);                              // R2
    do_write();
    do_request(0, 2, 1'b0);                        // R5 immediate launch
    do_write();
    do_request(3, 0, 1'b0);                        // R5 wait for cycle
    do_write();
    do_request(20, 3, 1'b0);                       // R6 capped
    do_write();
    do_request(DLY - 1, 1, 1'b0);                  // R6 boundary
    do_write();
    do_recall();
    do_request(0, 1, 1'b0);                        // R9 recall clears
    do_collide();
    do_request(0, 1, 1'b0);                        // R9 write wins
    do_write();
    do_request(2, 4, 1'b1);                        // R10
    for (int it = 0; it < 150; it++) begin
      case ($urandom_range(0, 4))
        0, 1: do_write();
        2:    do_recall();
        3:    do_glitch($urandom_range(1, G - 1));
        default: do_request($urandom_range(0, 11), $urandom_range(0, 5),
                            1'($urandom_range(0, 1)));
      endcase
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule